// File: doc/BRIEF.md
# Translation Fault Cause Encoder

This block sits at the end of an address translation step. For each access it takes the access kind and the pass/fail results of the checks already made on the translation. From these it produces one fault flag and one exception cause code. The checks are, in priority order: the privilege-mode check, the well-formedness check, the page permission check, and the capability store permission check. The inputs are sampled on a request strobe, and the result is presented one cycle later with a single-cycle response pulse.

The cause code is chosen from the access kind, not from the check that failed. Each access kind first gets its own default fault code. A store then gets a distinct capability store code only when the capability check is the single reason it faulted. Any earlier failed check keeps the plain store code.

The access kind is encoded as 0 = instruction fetch, 1 = data load, 2 = data store, 3 = reserved. The reserved value is treated as a load. All four codes are parameters. Their defaults are fetch 12, load 13, store 15 and capability store 27.

Top module: `tce_fault_cause`

## Requirements
- R1: While rst_ni is low and after its release, rsp_valid_o, fault_o and cause_o are all 0 until the first request is accepted.
- R2: rsp_valid_o is 1 in exactly the cycle after a cycle in which req_valid_i is 1, and 0 in every other cycle.
- R3: A failed privilege-mode check (mode_ok_i = 0) or a failed well-formedness check (form_ok_i = 0) sets fault_o to 1, for every access kind.
- R4: When no applicable check fails, fault_o is 0 and cause_o is 0.
- R5: A faulting instruction fetch (kind 0) reports cause FETCH_CODE (default 12).
- R6: A faulting data load (kind 1), or a faulting access of reserved kind 3, reports cause LOAD_CODE (default 13).
- R7: A faulting data store (kind 2) reports STORE_CODE (default 15) and never LOAD_CODE, including when the fault comes from the mode or well-formedness check.
- R8: A store that passes the mode, well-formedness and page permission checks but fails the capability check (cap_store_ok_i = 0) faults with cause CAP_STORE_CODE (default 27).
- R9: A store that fails any of the mode, well-formedness or page permission checks reports STORE_CODE whatever the value of cap_store_ok_i.
- R10: cap_store_ok_i has no effect on fetches or loads: with the other checks passing, such an access does not fault.
- R11: fault_o and cause_o keep their values in cycles following a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe; the check inputs are sampled when this is high |
| acc_kind_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 reserved (treated as load) |
| mode_ok_i | input | 1 | Privilege-mode check passed |
| form_ok_i | input | 1 | Well-formedness check passed |
| perm_ok_i | input | 1 | Page permission check passed |
| cap_store_ok_i | input | 1 | Capability store permission check passed |
| rsp_valid_o | output | 1 | One-cycle pulse marking a new result |
| fault_o | output | 1 | Translation fault |
| cause_o | output | CAUSE_W | Exception cause code; 0 when there is no fault |

## Verification
Each access kind is driven through five check patterns:
- all checks passing;
- only the mode check failing;
- only the well-formedness check failing;
- only the page permission check failing;
- only the capability check failing.

These patterns separate a cause chosen by access kind from a cause chosen by failed check. Stores are also driven with an early failure combined with a capability failure. That case tells a correctly blocked override apart from one that wrongly replaces the plain store code. Back-to-back requests and idle gaps check that every strobe gives exactly one response pulse and that results hold between requests.

// File: rtl/tce_pkg.sv
package tce_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // Check order: index 0 is the highest priority.
  localparam int unsigned N_EARLY  = 3;
  localparam int unsigned CHK_MODE = 0;
  localparam int unsigned CHK_FORM = 1;
  localparam int unsigned CHK_PERM = 2;
endpackage

// File: rtl/tce_check_eval.sv
module tce_check_eval
  import tce_pkg::*;
#(
  parameter int unsigned N_CHK = N_EARLY
) (
  input  acc_kind_e        kind_i,
  input  logic [N_CHK-1:0] ok_i,
  input  logic             cap_ok_i,
  output logic [N_CHK-1:0] fail_o,
  output logic             early_fail_o,
  output logic             cap_fail_o
);
  for (genvar g = 0; g < N_CHK; g++) begin : g_chk
    assign fail_o[g] = ~ok_i[g];
  end

  assign early_fail_o = |fail_o;
  // The capability check counts only for stores.
  assign cap_fail_o = (kind_i == ACC_STORE) && !cap_ok_i;
endmodule

// File: rtl/tce_cause_sel.sv
module tce_cause_sel
  import tce_pkg::*;
#(
  parameter int unsigned CAUSE_W        = 6,
  parameter int unsigned FETCH_CODE     = 12,
  parameter int unsigned LOAD_CODE      = 13,
  parameter int unsigned STORE_CODE     = 15,
  parameter int unsigned CAP_STORE_CODE = 27
) (
  input  acc_kind_e           kind_i,
  input  logic                early_fail_i,
  input  logic                cap_fail_i,
  output logic                fault_o,
  output logic [CAUSE_W-1:0]  cause_o
);
  localparam logic [CAUSE_W-1:0] C_FETCH = CAUSE_W'(FETCH_CODE);
  localparam logic [CAUSE_W-1:0] C_LOAD  = CAUSE_W'(LOAD_CODE);
  localparam logic [CAUSE_W-1:0] C_STORE = CAUSE_W'(STORE_CODE);
  localparam logic [CAUSE_W-1:0] C_CAP   = CAUSE_W'(CAP_STORE_CODE);

  logic [CAUSE_W-1:0] dflt_cause;

  always_comb begin
    unique case (kind_i)
      ACC_FETCH: dflt_cause = C_FETCH;
      ACC_STORE: dflt_cause = C_STORE;
      default:   dflt_cause = C_LOAD;
    endcase
  end

  always_comb begin
    fault_o = early_fail_i || cap_fail_i;
    cause_o = '0;
    if (fault_o) begin
      cause_o = dflt_cause;
      // The override applies only when no earlier check has failed.
      if (cap_fail_i && !early_fail_i) cause_o = C_CAP;
    end
  end
endmodule

// File: rtl/tce_out_reg.sv
module tce_out_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/tce_fault_cause.sv
module tce_fault_cause
  import tce_pkg::*;
#(
  parameter int unsigned CAUSE_W        = 6,
  parameter int unsigned FETCH_CODE     = 12,
  parameter int unsigned LOAD_CODE      = 13,
  parameter int unsigned STORE_CODE     = 15,
  parameter int unsigned CAP_STORE_CODE = 27
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         acc_kind_i,
  input  logic               mode_ok_i,
  input  logic               form_ok_i,
  input  logic               perm_ok_i,
  input  logic               cap_store_ok_i,
  output logic               rsp_valid_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int unsigned OUT_W = CAUSE_W + 1;

  acc_kind_e            kind;
  logic [N_EARLY-1:0]   ok_vec;
  logic [N_EARLY-1:0]   fail_vec;
  logic                 early_fail;
  logic                 cap_fail;
  logic                 fault_d;
  logic [CAUSE_W-1:0]   cause_d;
  logic [OUT_W-1:0]     out_q;

  assign kind             = acc_kind_e'(acc_kind_i);
  assign ok_vec[CHK_MODE] = mode_ok_i;
  assign ok_vec[CHK_FORM] = form_ok_i;
  assign ok_vec[CHK_PERM] = perm_ok_i;

  tce_check_eval #(.N_CHK(N_EARLY)) u_eval (
    .kind_i      (kind),
    .ok_i        (ok_vec),
    .cap_ok_i    (cap_store_ok_i),
    .fail_o      (fail_vec),
    .early_fail_o(early_fail),
    .cap_fail_o  (cap_fail)
  );

  tce_cause_sel #(
    .CAUSE_W       (CAUSE_W),
    .FETCH_CODE    (FETCH_CODE),
    .LOAD_CODE     (LOAD_CODE),
    .STORE_CODE    (STORE_CODE),
    .CAP_STORE_CODE(CAP_STORE_CODE)
  ) u_sel (
    .kind_i      (kind),
    .early_fail_i(early_fail),
    .cap_fail_i  (cap_fail),
    .fault_o     (fault_d),
    .cause_o     (cause_d)
  );

  tce_out_reg #(.W(OUT_W)) u_oreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (req_valid_i),
    .d_i   ({fault_d, cause_d}),
    .vld_o (rsp_valid_o),
    .q_o   (out_q)
  );

  assign fault_o = out_q[OUT_W-1];
  assign cause_o = out_q[CAUSE_W-1:0];

  logic unused_fail;
  assign unused_fail = ^fail_vec;
endmodule

// File: rtl/tce_fault_cause_chk.sv
module tce_fault_cause_chk #(
  parameter int unsigned CAUSE_W        = 6,
  parameter int unsigned STORE_CODE     = 15,
  parameter int unsigned LOAD_CODE      = 13,
  parameter int unsigned CAP_STORE_CODE = 27
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [1:0]         acc_kind_i,
  input logic               mode_ok_i,
  input logic               form_ok_i,
  input logic               perm_ok_i,
  input logic               cap_store_ok_i,
  input logic               rsp_valid_o,
  input logic               fault_o,
  input logic [CAUSE_W-1:0] cause_o
);
  localparam logic [CAUSE_W-1:0] C_STORE = CAUSE_W'(STORE_CODE);
  localparam logic [CAUSE_W-1:0] C_LOAD  = CAUSE_W'(LOAD_CODE);
  localparam logic [CAUSE_W-1:0] C_CAP   = CAUSE_W'(CAP_STORE_CODE);

  p_rsp_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_early_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (!mode_ok_i || !form_ok_i) |=> fault_o);
  p_clean_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !fault_o |-> cause_o == '0);
  p_store_not_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && acc_kind_i == 2'd2 && !mode_ok_i |=> cause_o == C_STORE && cause_o != C_LOAD);
  p_cap_override_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && acc_kind_i == 2'd2 && mode_ok_i && form_ok_i && perm_ok_i && !cap_store_ok_i
    |=> fault_o && cause_o == C_CAP);
  p_cap_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && acc_kind_i == 2'd2 && !(mode_ok_i && form_ok_i && perm_ok_i)
    |=> cause_o == C_STORE);
  p_cap_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && acc_kind_i != 2'd2 && mode_ok_i && form_ok_i && perm_ok_i |=> !fault_o);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(fault_o) && $stable(cause_o));
endmodule

bind tce_fault_cause tce_fault_cause_chk #(
  .CAUSE_W(CAUSE_W), .STORE_CODE(STORE_CODE), .LOAD_CODE(LOAD_CODE),
  .CAP_STORE_CODE(CAP_STORE_CODE)
) u_chk (.*);

// File: tb/sim_tce_fault_cause.sv
`timescale 1ns/1ps
module sim_tce_fault_cause;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [1:0]    acc_kind_i = '0;
  logic          mode_ok_i = 1'b1, form_ok_i = 1'b1, perm_ok_i = 1'b1, cap_store_ok_i = 1'b1;
  logic          rsp_valid_o, fault_o;
  logic [CW-1:0] cause_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tce_fault_cause u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .acc_kind_i(acc_kind_i),
    .mode_ok_i(mode_ok_i), .form_ok_i(form_ok_i), .perm_ok_i(perm_ok_i),
    .cap_store_ok_i(cap_store_ok_i), .rsp_valid_o(rsp_valid_o), .fault_o(fault_o),
    .cause_o(cause_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Independent model from the requirements.
  function automatic void model(input int k, input bit m, input bit f, input bit p, input bit c,
                                output bit flt, output int cs);
    bit early;
    early = !m || !f || !p;
    flt = early || (k == 2 && !c);
    if (!flt) cs = 0;
    else if (k == 0) cs = 12;
    else if (k == 2) cs = (!early) ? 27 : 15;
    else cs = 13;
  endfunction

  // One request; the result is registered at the next edge and sampled at the following negedge.
  task automatic one_req(input string req, input int k, input bit m, input bit f,
                         input bit p, input bit c);
    bit ef; int ec;
    model(k, m, f, p, c, ef, ec);
    @(negedge clk);
    acc_kind_i = k[1:0]; mode_ok_i = m; form_ok_i = f; perm_ok_i = p; cap_store_ok_i = c;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk({req, " R2 valid"}, int'(rsp_valid_o), 1);
    chk({req, " fault"}, int'(fault_o), int'(ef));
    chk({req, " cause"}, int'(cause_o), ec);
  endtask

  task automatic t_reset;
    chk("R1 valid", int'(rsp_valid_o), 0);
    chk("R1 fault", int'(fault_o), 0);
    chk("R1 cause", int'(cause_o), 0);
  endtask

  task automatic t_kinds;
    for (int k = 0; k < 4; k++) begin
      one_req("R4 clean", k, 1, 1, 1, 1);
      one_req("R3 mode", k, 0, 1, 1, 1);
      one_req("R3 form", k, 1, 0, 1, 1);
      one_req(k == 0 ? "R5 perm" : (k == 2 ? "R7 perm" : "R6 perm"), k, 1, 1, 0, 1);
      one_req(k == 2 ? "R8 cap" : "R10 cap", k, 1, 1, 1, 0);
    end
  endtask

  task automatic t_store_prio;
    one_req("R9 mode+cap", 2, 0, 1, 1, 0);
    one_req("R9 form+cap", 2, 1, 0, 1, 0);
    one_req("R9 perm+cap", 2, 1, 1, 0, 0);
    one_req("R7 mode store", 2, 0, 1, 1, 1);
  endtask

  task automatic t_hold;
    one_req("R11 setup", 2, 1, 1, 1, 0);
    // Change inputs without a strobe; outputs must not move.
    @(negedge clk);
    acc_kind_i = 2'd0; mode_ok_i = 1'b1; cap_store_ok_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 no pulse", int'(rsp_valid_o), 0);
      chk("R11 fault", int'(fault_o), 1);
      chk("R11 cause", int'(cause_o), 27);
    end
  endtask

  task automatic t_back2back;
    @(negedge clk);
    acc_kind_i = 2'd0; mode_ok_i = 1'b0; req_valid_i = 1'b1;
    @(negedge clk);
    chk("R2 b2b 1", int'(rsp_valid_o), 1);
    chk("R5 b2b 1", int'(cause_o), 12);
    acc_kind_i = 2'd1;
    @(negedge clk);
    req_valid_i = 1'b0; mode_ok_i = 1'b1;
    chk("R2 b2b 2", int'(rsp_valid_o), 1);
    chk("R6 b2b 2", int'(cause_o), 13);
    @(negedge clk);
    chk("R2 b2b end", int'(rsp_valid_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_kinds();
    t_store_prio();
    t_hold();
    t_back2back();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule